// File: doc/BRIEF.md
# Prioritized Interrupt Entry Controller

This block decides whether a pending hardware interrupt request is taken by the processor, and how. When a request is taken, it produces every register update in one cycle: the processor status word, the per-level saved program counter and saved status slots, an optional double-exception PC, and the exception-cause register. It also produces the redirected program counter and a one-cycle taken pulse.

Levels above 1 are high-priority. Each of them vectors straight to its own handler and records state in its own saved slots. A level-1 request is folded into the general exception path instead. It becomes a kernel, user or double exception, chosen by the exception-mode and user-mode bits of the status word. All handler addresses can be relocated at run time against a live vector base. An exception kind whose configured vector is zero still commits its register writes, but it does not redirect the PC.

The request is sampled on a rising clock edge. All results appear on registered outputs during the following cycle, and they last for that one cycle only.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A request is accepted only when `req_valid` is high, `req_level` is greater than `cur_level`, `req_level` is no greater than NUM_LEVELS, and the AND of that level's mask with `int_set` and `int_enable` is nonzero. Level L's mask sits at bits [(L-1)*IRQ_W +: IRQ_W] of `level_masks`. A request that is not accepted raises no write enable and no `taken`.
- R2: An accepted level L>1 writes `pc_in` to saved-PC slot L-1 (`epc_sel`) and writes `ps_in` to saved-status slot L-2 (`eps_sel`). Saved-status slot 0 therefore belongs to level 2.
- R3: An accepted level L>1 writes the status word as `ps_in` with bits [3:0] replaced by L and bit 4 (exception mode) set. `pc_next` is then LVL_VEC0 + (L-2)*LVL_VEC_STRIDE, and `taken` is high.
- R4: An accepted level-1 request writes LEVEL1_CAUSE (default 4) to the cause register. A high-level entry never writes the cause register.
- R5: A level-1 request taken while `ps_in` bit 4 is set is a double exception with target DOUBLE_VEC. With HAS_DEPC=1 the PC goes to `depc_val`. With HAS_DEPC=0 it goes to saved-PC slot 0.
- R6: A level-1 request taken while `ps_in` bit 4 is clear writes the PC to saved-PC slot 0. It is a user exception (USER_VEC) if `ps_in` bit 5 is set and a kernel exception (KERNEL_VEC) otherwise. In every level-1 case the status word is written as `ps_in` with bit 4 set.
- R7: When `reloc_en` is high, the target equals the static vector minus STATIC_VECBASE plus `vecbase_in`.
- R8: If the selected exception vector is zero, `taken` stays low and no redirect occurs, but the register writes of that entry are still performed.
- R9: Outputs change on the clock edge that samples an accepted request, and they last one cycle. With no new request, the next cycle shows every write enable and `taken` low.
- R10: `entry_kind` reports the entry taken: 0 none, 1 high-level, 2 kernel, 3 user, 4 double.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A pending request is presented this cycle |
| req_level | input | 4 | Level of the pending request |
| cur_level | input | 4 | Current interrupt level of the processor |
| int_set | input | IRQ_W | Raised interrupt lines |
| int_enable | input | IRQ_W | Enabled interrupt lines |
| level_masks | input | NUM_LEVELS*IRQ_W | Per-level line masks, level 1 in the lowest slice |
| ps_in | input | 32 | Current status word |
| pc_in | input | 32 | Current program counter |
| vecbase_in | input | 32 | Live vector base |
| reloc_en | input | 1 | Apply vector relocation |
| taken | output | 1 | One-cycle pulse: PC redirected to `pc_next` |
| pc_next | output | 32 | Handler address |
| entry_kind | output | 3 | Kind of entry (R10 encoding) |
| ps_we | output | 1 | Status word write |
| ps_val | output | 32 | New status word |
| epc_we | output | 1 | Saved-PC slot write |
| epc_sel | output | clog2(NUM_LEVELS) | Saved-PC slot, level minus 1 |
| epc_val | output | 32 | Saved PC |
| eps_we | output | 1 | Saved-status slot write |
| eps_sel | output | clog2(NUM_LEVELS) | Saved-status slot, level minus 2 |
| eps_val | output | 32 | Saved status word |
| depc_we | output | 1 | Double-exception PC write |
| depc_val | output | 32 | Double-exception saved PC |
| cause_we | output | 1 | Cause register write |
| cause_val | output | 6 | Cause value |

## Verification
The bench probes the edges of the acceptance test. It tries a level equal to the current level, a level above NUM_LEVELS whose mask window would otherwise match, lines that are set but not enabled, and level zero. A comparator that was off by one would take these entries and redirect the PC.

It walks every level-1 routing case with HAS_DEPC set and with HAS_DEPC cleared. The no-DEPC instance also has a zero double vector, so a design that skipped the register writes, or still pulsed `taken`, would show it there. The bench also checks both slot offsets at the lowest and highest levels, and relocation against two different live bases, to expose swapped slot bias or relocation arithmetic.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int REG_W       = 32;
  localparam int PS_LVL_W    = 4;
  localparam int PS_EXCM_BIT = 4;
  localparam int PS_UM_BIT   = 5;

  typedef logic [REG_W-1:0]    word_t;
  typedef logic [PS_LVL_W-1:0] lvl_t;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_HIGH   = 3'd1,
    KIND_KERNEL = 3'd2,
    KIND_USER   = 3'd3,
    KIND_DOUBLE = 3'd4
  } entry_kind_e;

  // Move a static vector from its build-time base onto the live base.
  function automatic word_t reloc_target(word_t static_vec, word_t static_base,
                                         word_t live_base, logic en);
    return en ? (static_vec - static_base + live_base) : static_vec;
  endfunction

  function automatic word_t set_excm(word_t ps);
    word_t r;
    r = ps;
    r[PS_EXCM_BIT] = 1'b1;
    return r;
  endfunction

  function automatic word_t ps_enter_high(word_t ps, lvl_t lvl);
    word_t r;
    r = set_excm(ps);
    r[PS_LVL_W-1:0] = lvl;
    return r;
  endfunction
endpackage

// File: rtl/irq_accept_chk.sv
module irq_accept_chk
  import irq_entry_pkg::*;
#(
  parameter int NUM_LEVELS = 6,
  parameter int IRQ_W      = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  lvl_t                        req_level,
  input  lvl_t                        cur_level,
  input  logic [IRQ_W-1:0]            int_set,
  input  logic [IRQ_W-1:0]            int_enable,
  input  logic [NUM_LEVELS*IRQ_W-1:0] level_masks,
  output logic                        accept
);
  logic [IRQ_W-1:0] mask_sel;
  logic [IRQ_W-1:0] hit_bits;
  logic             level_ok;

  always_comb begin
    mask_sel = '0;
    for (int l = 1; l <= NUM_LEVELS; l++) begin
      if (req_level == lvl_t'(l)) mask_sel = level_masks[(l-1)*IRQ_W +: IRQ_W];
    end
  end

  assign hit_bits = mask_sel & int_set & int_enable;
  assign level_ok = (req_level > cur_level) && (req_level <= lvl_t'(NUM_LEVELS));
  assign accept   = req_valid && level_ok && (|hit_bits);

  // R1: an accepted level is never zero and always has a live, enabled line
  a_r1_accept_has_line: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (req_level != '0) && ((int_set & int_enable) != '0));
endmodule

// File: rtl/irq_kind_sel.sv
module irq_kind_sel
  import irq_entry_pkg::*;
#(
  parameter word_t LVL_VEC0       = 32'h4000_0180,
  parameter word_t LVL_VEC_STRIDE = 32'h0000_0040,
  parameter word_t KERNEL_VEC     = 32'h4000_0300,
  parameter word_t USER_VEC       = 32'h4000_0340,
  parameter word_t DOUBLE_VEC     = 32'h4000_03C0
) (
  input  lvl_t        level,
  input  word_t       ps,
  output entry_kind_e kind,
  output word_t       static_vec
);
  always_comb begin
    if (level > lvl_t'(1)) begin
      kind       = KIND_HIGH;
      static_vec = LVL_VEC0 + LVL_VEC_STRIDE * (word_t'(level) - word_t'(2));
    end else if (ps[PS_EXCM_BIT]) begin
      kind       = KIND_DOUBLE;
      static_vec = DOUBLE_VEC;
    end else if (ps[PS_UM_BIT]) begin
      kind       = KIND_USER;
      static_vec = USER_VEC;
    end else begin
      kind       = KIND_KERNEL;
      static_vec = KERNEL_VEC;
    end
  end
endmodule

// File: rtl/irq_vec_reloc.sv
module irq_vec_reloc
  import irq_entry_pkg::*;
#(
  parameter word_t STATIC_VECBASE = 32'h4000_0000
) (
  input  word_t static_vec,
  input  word_t vecbase,
  input  logic  reloc_en,
  output word_t target,
  output logic  has_vec
);
  assign has_vec = (static_vec != '0);
  assign target  = reloc_target(static_vec, STATIC_VECBASE, vecbase, reloc_en);
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int    NUM_LEVELS     = 6,
  parameter int    IRQ_W          = 32,
  parameter bit    HAS_DEPC       = 1'b1,
  parameter word_t STATIC_VECBASE = 32'h4000_0000,
  parameter word_t LVL_VEC0       = 32'h4000_0180,
  parameter word_t LVL_VEC_STRIDE = 32'h0000_0040,
  parameter word_t KERNEL_VEC     = 32'h4000_0300,
  parameter word_t USER_VEC       = 32'h4000_0340,
  parameter word_t DOUBLE_VEC     = 32'h4000_03C0,
  parameter int    CAUSE_W        = 6,
  parameter int    LEVEL1_CAUSE   = 4,
  localparam int   SLOT_W         = $clog2(NUM_LEVELS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  input  logic [PS_LVL_W-1:0]         req_level,
  input  logic [PS_LVL_W-1:0]         cur_level,
  input  logic [IRQ_W-1:0]            int_set,
  input  logic [IRQ_W-1:0]            int_enable,
  input  logic [NUM_LEVELS*IRQ_W-1:0] level_masks,
  input  logic [REG_W-1:0]            ps_in,
  input  logic [REG_W-1:0]            pc_in,
  input  logic [REG_W-1:0]            vecbase_in,
  input  logic                        reloc_en,
  output logic                        taken,
  output logic [REG_W-1:0]            pc_next,
  output logic [2:0]                  entry_kind,
  output logic                        ps_we,
  output logic [REG_W-1:0]            ps_val,
  output logic                        epc_we,
  output logic [SLOT_W-1:0]           epc_sel,
  output logic [REG_W-1:0]            epc_val,
  output logic                        eps_we,
  output logic [SLOT_W-1:0]           eps_sel,
  output logic [REG_W-1:0]            eps_val,
  output logic                        depc_we,
  output logic [REG_W-1:0]            depc_val,
  output logic                        cause_we,
  output logic [CAUSE_W-1:0]          cause_val
);
  // Named internal events, observed by the assertions below
  logic        accept;
  entry_kind_e kind;
  entry_kind_e kind_q;
  word_t       static_vec;
  word_t       target;
  logic        has_vec;

  irq_accept_chk #(.NUM_LEVELS(NUM_LEVELS), .IRQ_W(IRQ_W)) u_accept (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .cur_level(cur_level), .int_set(int_set), .int_enable(int_enable),
    .level_masks(level_masks), .accept(accept)
  );

  irq_kind_sel #(
    .LVL_VEC0(LVL_VEC0), .LVL_VEC_STRIDE(LVL_VEC_STRIDE),
    .KERNEL_VEC(KERNEL_VEC), .USER_VEC(USER_VEC), .DOUBLE_VEC(DOUBLE_VEC)
  ) u_kind (
    .level(req_level), .ps(ps_in), .kind(kind), .static_vec(static_vec)
  );

  irq_vec_reloc #(.STATIC_VECBASE(STATIC_VECBASE)) u_reloc (
    .static_vec(static_vec), .vecbase(vecbase_in), .reloc_en(reloc_en),
    .target(target), .has_vec(has_vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken <= 1'b0; pc_next <= '0; kind_q <= KIND_NONE;
      ps_we <= 1'b0; ps_val <= '0;
      epc_we <= 1'b0; epc_sel <= '0; epc_val <= '0;
      eps_we <= 1'b0; eps_sel <= '0; eps_val <= '0;
      depc_we <= 1'b0; depc_val <= '0;
      cause_we <= 1'b0; cause_val <= '0;
    end else begin
      taken    <= 1'b0;
      kind_q   <= KIND_NONE;
      ps_we    <= 1'b0;
      epc_we   <= 1'b0;
      eps_we   <= 1'b0;
      depc_we  <= 1'b0;
      cause_we <= 1'b0;
      if (accept) begin
        kind_q <= kind;
        taken  <= has_vec;
        if (has_vec) pc_next <= target;
        ps_we  <= 1'b1;
        if (kind == KIND_HIGH) begin
          ps_val  <= ps_enter_high(ps_in, req_level);
          epc_we  <= 1'b1;
          epc_sel <= SLOT_W'(req_level - lvl_t'(1));
          epc_val <= pc_in;
          eps_we  <= 1'b1;
          eps_sel <= SLOT_W'(req_level - lvl_t'(2));
          eps_val <= ps_in;
        end else begin
          ps_val    <= set_excm(ps_in);
          cause_we  <= 1'b1;
          cause_val <= CAUSE_W'(LEVEL1_CAUSE);
          if (kind == KIND_DOUBLE && HAS_DEPC) begin
            depc_we  <= 1'b1;
            depc_val <= pc_in;
          end else begin
            epc_we  <= 1'b1;
            epc_sel <= '0;
            epc_val <= pc_in;
          end
        end
      end
    end
  end

  assign entry_kind = kind_q;

  // R1: no request, no side effect in the next cycle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !(taken || ps_we || epc_we || eps_we || depc_we || cause_we));
  // R2: saved-status slots sit one below the saved-PC slots
  a_r2_slot_bias: assert property (@(posedge clk) disable iff (!rst_n)
    eps_we |-> (epc_we && (epc_sel == eps_sel + SLOT_W'(1))));
  // R3: high-level entry puts its own level into the status word
  a_r3_high_level_field: assert property (@(posedge clk) disable iff (!rst_n)
    eps_we |-> (ps_val[PS_LVL_W-1:0] == lvl_t'(eps_sel) + lvl_t'(2)));
  // R4: only level-1 entries touch the cause register
  a_r4_cause_level1: assert property (@(posedge clk) disable iff (!rst_n)
    cause_we |-> (!eps_we && cause_val == CAUSE_W'(LEVEL1_CAUSE)));
  // R5: a double exception saves the PC in exactly one place
  a_r5_double_one_dest: assert property (@(posedge clk) disable iff (!rst_n)
    depc_we |-> !epc_we);
  // R6: every entry leaves exception mode set
  a_r6_excm_after: assert property (@(posedge clk) disable iff (!rst_n)
    ps_we |-> ps_val[PS_EXCM_BIT]);
  // R9: a redirect only accompanies a committed entry
  a_r9_taken_commits: assert property (@(posedge clk) disable iff (!rst_n)
    taken |-> (ps_we && kind_q != KIND_NONE));
  // R10: reported kind agrees with which slots were written
  a_r10_kind_high: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == KIND_HIGH) |-> (eps_we && !cause_we));
endmodule

// File: tb/tb_irq_entry_ctrl.sv
`timescale 1ns/1ps
module tb_irq_entry_ctrl;
  localparam int NL  = 6;
  localparam int IW  = 32;
  localparam int SW  = $clog2(NL);
  localparam real TCK = 8.0;

  typedef struct packed {
    logic [3:0]  lvl;
    logic [3:0]  cur;
    logic [31:0] ps;
    logic [31:0] iset;
    logic [31:0] ien;
    logic        reloc;
    logic [31:0] vb;
  } vec_t;

  localparam vec_t VECS [0:11] = '{
    '{4'd3, 4'd0, 32'h0000_0020, 32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0},
    '{4'd2, 4'd1, 32'h0000_0001, 32'h0000_0010, 32'h0000_00F0, 1'b1, 32'h6000_0000},
    '{4'd3, 4'd3, 32'h0000_0000, 32'h0000_0100, 32'h0000_0100, 1'b0, 32'h0},
    '{4'd7, 4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0},
    '{4'd2, 4'd0, 32'h0000_0000, 32'h0000_0100, 32'hFFFF_FFFF, 1'b0, 32'h0},
    '{4'd2, 4'd0, 32'h0000_0000, 32'h0000_0010, 32'h0000_0020, 1'b0, 32'h0},
    '{4'd1, 4'd0, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 1'b0, 32'h0},
    '{4'd1, 4'd0, 32'h0000_0020, 32'h0000_0002, 32'h0000_0002, 1'b0, 32'h0},
    '{4'd1, 4'd0, 32'h0000_0010, 32'h0000_0004, 32'h0000_0004, 1'b0, 32'h0},
    '{4'd6, 4'd5, 32'hFFFF_FFF5, 32'h0010_0000, 32'h00F0_0000, 1'b0, 32'h0},
    '{4'd1, 4'd0, 32'h0000_0020, 32'h0000_0008, 32'h0000_0008, 1'b1, 32'h8000_0000},
    '{4'd0, 4'd0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 32'h0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [3:0] req_level = '0, cur_level = '0;
  logic [IW-1:0] int_set = '0, int_enable = '0;
  logic [NL*IW-1:0] level_masks = '0;
  logic [31:0] ps_in = '0, pc_in = '0, vecbase_in = '0;
  logic reloc_en = 1'b0;

  logic taken, ps_we, epc_we, eps_we, depc_we, cause_we;
  logic [31:0] pc_next, ps_val, epc_val, eps_val, depc_val;
  logic [2:0] entry_kind;
  logic [SW-1:0] epc_sel, eps_sel;
  logic [5:0] cause_val;

  logic n_taken, n_ps_we, n_epc_we, n_eps_we, n_depc_we, n_cause_we;
  logic [31:0] n_pc_next, n_ps_val, n_epc_val, n_eps_val, n_depc_val;
  logic [2:0] n_kind;
  logic [SW-1:0] n_epc_sel, n_eps_sel;
  logic [5:0] n_cause_val;

  int n_chk = 0;
  int n_fail = 0;

  always #(TCK/2) clk = ~clk;

  irq_entry_ctrl #(.NUM_LEVELS(NL), .IRQ_W(IW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .cur_level(cur_level), .int_set(int_set), .int_enable(int_enable),
    .level_masks(level_masks), .ps_in(ps_in), .pc_in(pc_in),
    .vecbase_in(vecbase_in), .reloc_en(reloc_en),
    .taken(taken), .pc_next(pc_next), .entry_kind(entry_kind),
    .ps_we(ps_we), .ps_val(ps_val), .epc_we(epc_we), .epc_sel(epc_sel),
    .epc_val(epc_val), .eps_we(eps_we), .eps_sel(eps_sel), .eps_val(eps_val),
    .depc_we(depc_we), .depc_val(depc_val), .cause_we(cause_we), .cause_val(cause_val)
  );

  irq_entry_ctrl #(.NUM_LEVELS(NL), .IRQ_W(IW), .HAS_DEPC(1'b0),
                   .DOUBLE_VEC(32'h0)) dut_nv (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
    .cur_level(cur_level), .int_set(int_set), .int_enable(int_enable),
    .level_masks(level_masks), .ps_in(ps_in), .pc_in(pc_in),
    .vecbase_in(vecbase_in), .reloc_en(reloc_en),
    .taken(n_taken), .pc_next(n_pc_next), .entry_kind(n_kind),
    .ps_we(n_ps_we), .ps_val(n_ps_val), .epc_we(n_epc_we), .epc_sel(n_epc_sel),
    .epc_val(n_epc_val), .eps_we(n_eps_we), .eps_sel(n_eps_sel), .eps_val(n_eps_val),
    .depc_we(n_depc_we), .depc_val(n_depc_val), .cause_we(n_cause_we),
    .cause_val(n_cause_val)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int l;
    logic [31:0] m, pc, ofs, tgt;
    logic acc;
    logic [2:0] ek;
    l  = int'(v.lvl);
    m  = (l >= 1 && l <= NL) ? (32'hF << ((l-1)*4)) : 32'h0;
    acc = (v.lvl > v.cur) && (l <= NL) && ((m & v.iset & v.ien) != 0);
    pc = 32'h0000_1000 + 32'(idx) * 4;
    if (!acc)        ek = 3'd0;
    else if (l > 1)  ek = 3'd1;
    else if (v.ps[4]) ek = 3'd4;
    else if (v.ps[5]) ek = 3'd3;
    else             ek = 3'd2;
    case (ek)
      3'd1:    ofs = 32'h180 + 32'(l-2) * 32'h40;
      3'd2:    ofs = 32'h300;
      3'd3:    ofs = 32'h340;
      3'd4:    ofs = 32'h3C0;
      default: ofs = 32'h0;
    endcase
    tgt = (v.reloc ? v.vb : 32'h4000_0000) + ofs;

    @(negedge clk);
    req_level = v.lvl; cur_level = v.cur; ps_in = v.ps; int_set = v.iset;
    int_enable = v.ien; reloc_en = v.reloc; vecbase_in = v.vb; pc_in = pc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 kind", 32'(entry_kind), 32'(ek));
    chk("R1 taken", 32'(taken), 32'(acc));
    if (!acc) begin
      chk("R1 rejected writes", {ps_we, epc_we, eps_we, depc_we, cause_we}, 32'h0);
    end else if (ek == 3'd1) begin
      chk("R2 epc_we", 32'(epc_we), 32'h1);
      chk("R2 epc_sel", 32'(epc_sel), 32'(l-1));
      chk("R2 epc_val", epc_val, pc);
      chk("R2 eps_sel", 32'(eps_sel), 32'(l-2));
      chk("R2 eps_val", eps_val, v.ps);
      chk("R3 ps_val", ps_val, {v.ps[31:4], v.lvl} | 32'h10);
      chk(v.reloc ? "R7 high target" : "R3 high target", pc_next, tgt);
      chk("R4 no cause on high", 32'(cause_we), 32'h0);
    end else begin
      chk("R4 cause_we", 32'(cause_we), 32'h1);
      chk("R4 cause_val", 32'(cause_val), 32'h4);
      chk("R6 ps_val", ps_val, v.ps | 32'h10);
      chk(v.reloc ? "R7 exc target" : "R6 exc target", pc_next, tgt);
      chk("R6 no eps", 32'(eps_we), 32'h0);
      if (ek == 3'd4) begin
        chk("R5 depc_we", 32'(depc_we), 32'h1);
        chk("R5 depc_val", depc_val, pc);
        chk("R5 no epc", 32'(epc_we), 32'h0);
      end else begin
        chk("R6 epc_we", 32'(epc_we), 32'h1);
        chk("R6 epc_sel", 32'(epc_sel), 32'h0);
        chk("R6 epc_val", epc_val, pc);
      end
    end
    @(negedge clk);
    chk("R9 pulse ends", {taken, ps_we, epc_we, eps_we, depc_we, cause_we}, 32'h0);
  endtask

  initial begin
    for (int lv = 1; lv <= NL; lv++)
      level_masks[(lv-1)*IW +: IW] = 32'hF << ((lv-1)*4);
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", {taken, ps_we, epc_we, eps_we, depc_we, cause_we}, 32'h0);
    chk("R10 reset kind", 32'(entry_kind), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) run_vec(i, VECS[i]);

    // R1: accepting inputs with req_valid low leave everything idle
    @(negedge clk);
    req_level = 4'd2; cur_level = 4'd0; int_set = 32'h10; int_enable = 32'h10;
    ps_in = 32'h0; reloc_en = 1'b0; req_valid = 1'b0;
    @(negedge clk);
    chk("R1 no valid no writes", {taken, ps_we, epc_we, eps_we, depc_we, cause_we}, 32'h0);

    // R5/R8: double exception on the instance with no DEPC and a zero vector
    req_level = 4'd1; ps_in = 32'h10; int_set = 32'h1; int_enable = 32'h1;
    pc_in = 32'h2222_0000; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 zero vector no taken", 32'(n_taken), 32'h0);
    chk("R8 zero vector still writes ps", 32'(n_ps_we), 32'h1);
    chk("R8 zero vector still writes cause", 32'(n_cause_we), 32'h1);
    chk("R5 no depc uses epc", 32'(n_epc_we), 32'h1);
    chk("R5 no depc epc slot", 32'(n_epc_sel), 32'h0);
    chk("R5 no depc epc value", n_epc_val, 32'h2222_0000);
    chk("R5 no depc write", 32'(n_depc_we), 32'h0);
    chk("R10 double kind", 32'(n_kind), 32'h4);
    chk("R5 with depc taken", 32'(taken), 32'h1);

    // R9: back-to-back requests each give their own one-cycle result
    @(negedge clk);
    req_level = 4'd2; ps_in = 32'h0; int_set = 32'h10; int_enable = 32'h10; req_valid = 1'b1;
    @(negedge clk);
    req_level = 4'd3; int_set = 32'h100; int_enable = 32'h100;
    chk("R9 first of pair", 32'(eps_sel), 32'h0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 second of pair", 32'(eps_sel), 32'h1);
    chk("R9 second taken", 32'(taken), 32'h1);
    @(negedge clk);
    chk("R9 pair ends", 32'(taken), 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(TCK * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule